// File: doc/BRIEF.md
# Multi-Cycle RV32I Harvard Core

This block is a compact 32-bit RISC-V integer processor. It decodes the base integer instruction set and runs one instruction at a time. Each instruction is fetched over its own instruction-side master port, decoded, given its operands from the register file or the immediate field, executed with any branch or jump resolved, and then either retired at once or passed to a data-side master port. A load writes the register file when its data phase completes. The two master ports follow a simplified AHB-Lite protocol: one single NONSEQ transfer per access, with no bursts and no sequential beats. The machine is therefore Harvard, with separate instruction and data address spaces.

On each port the slave's `hready` is the only back-pressure. The core holds the address, the transfer type and the write flag while the address phase is stalled. It holds the write data while the data phase is stalled. It takes read data only in a cycle where `hready` is high. With zero-wait-state memories, an arithmetic, branch or jump instruction takes two cycles and a load or store takes four. Anything outside the supported subset, and any word access or control transfer to an address that is not word aligned, stops the core for good with `halted` raised. Only a reset clears it.

Top module: `rv32_harvard_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both ports drive `htrans` = IDLE (2'b00). In the second cycle after release the instruction port drives NONSEQ (2'b10) at address 0x00000000, the data port stays IDLE and `halted` is low.
- R2: Register-register operations use the standard RV32I encoding (opcode 0110011). They are ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR and AND, and they give the architectural result. Shifts use only the low 5 bits of rs2.
- R3: Register-immediate operations (opcode 0010011) give the architectural result with a sign-extended 12-bit immediate. They are ADDI, SLTI, SLTIU, XORI, ORI, ANDI, SLLI, SRLI and SRAI.
- R4: The six conditional branches (opcode 1100011, funct3 000/001/100/101/110/111) go to pc+imm when the condition holds and to pc+4 when it does not. This holds for backward targets too.
- R5: LUI loads imm<<12. AUIPC adds imm<<12 to its own pc. JAL and JALR write pc+4 to rd. JALR jumps to (rs1+imm) with bit 0 cleared.
- R6: LW and SW (funct3 010) access the word at rs1+sign-extended offset. Each access is one NONSEQ data transfer, with `hwrite` high for a store.
- R7: Register x0 always reads as zero. A write to it has no effect.
- R8: Only one port is active at a time. With zero wait states, the next fetch is issued 2 cycles after the fetch of a non-memory instruction and 4 cycles after the fetch of a load or store.
- R9: When `hready` is low on either port, that port holds its transfer, and the architectural results equal those of a zero-wait run.
- R10: An unsupported instruction halts the core without a trap. Examples are an all-zero word, a byte load, FENCE, ECALL, and a funct7 that is invalid for the opcode. After the halt `halted` stays high, both ports stay IDLE and no later store takes place.
- R11: A load or store whose address is not a multiple of 4 halts the core with no data transfer. So does a jump or taken branch to an address that is not a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ibus_haddr | output | 32 | Instruction fetch address (current pc) |
| ibus_htrans | output | 2 | Fetch transfer type: 2'b00 IDLE, 2'b10 NONSEQ |
| ibus_hready | input | 1 | Instruction slave ready; low stretches the current phase |
| ibus_hrdata | input | 32 | Instruction word returned in the fetch data phase |
| dbus_haddr | output | 32 | Data transfer address |
| dbus_htrans | output | 2 | Data transfer type: 2'b00 IDLE, 2'b10 NONSEQ |
| dbus_hwrite | output | 1 | High for a store, low for a load |
| dbus_hwdata | output | 32 | Store data, valid throughout the data phase |
| dbus_hready | input | 1 | Data slave ready; low stretches the current phase |
| dbus_hrdata | input | 32 | Load data returned in the data phase |
| halted | output | 1 | Sticky flag: an illegal or misaligned operation stopped the core |

## Verification
The assertions assume that each slave answers a NONSEQ transfer with one data phase and that `hready` is the only stall mechanism. Read data is taken as valid in every cycle where `hready` is high during a data phase, and no error response is ever given. The bench's behavioural memories keep to these rules. They latch the address phase only when `hready` is high, and in the stalled runs they derive `hready` from a free-running LFSR that is independent of the core. Every program the bench builds places instructions and data inside the modelled memories, so each fetch and each aligned access returns defined data.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int XLEN = 32;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef enum logic [1:0] {ASEL_RS1, ASEL_PC, ASEL_ZERO} asel_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_FADDR, ST_FDATA, ST_DADDR, ST_DDATA, ST_HALT
  } state_e;

  typedef struct packed {
    alu_op_e         op;
    asel_e           asel;
    logic            bsel_imm;
    logic [XLEN-1:0] imm;
    logic            is_br;
    logic            is_jal;
    logic            is_jalr;
    logic            is_ld;
    logic            is_st;
    logic            wr;
    logic            bad;
    logic [4:0]      rs1;
    logic [4:0]      rs2;
    logic [4:0]      rd;
    logic [2:0]      f3;
  } dec_t;
endpackage

// File: rtl/rvc_decode.sv
module rvc_decode import rvc_pkg::*; (
  input  logic [31:0] instr,
  output dec_t        dec
);
  function automatic alu_op_e op_of(input logic [2:0] f3, input logic alt);
    case (f3)
      3'd0:    op_of = alt ? ALU_SUB : ALU_ADD;
      3'd1:    op_of = ALU_SLL;
      3'd2:    op_of = ALU_SLT;
      3'd3:    op_of = ALU_SLTU;
      3'd4:    op_of = ALU_XOR;
      3'd5:    op_of = alt ? ALU_SRA : ALU_SRL;
      3'd6:    op_of = ALU_OR;
      default: op_of = ALU_AND;
    endcase
  endfunction

  logic [6:0]  opc, f7;
  logic [2:0]  f3;
  logic [31:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  always_comb begin
    opc   = instr[6:0];
    f3    = instr[14:12];
    f7    = instr[31:25];
    imm_i = {{20{instr[31]}}, instr[31:20]};
    imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    imm_u = {instr[31:12], 12'b0};
    imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

    dec      = '0;
    dec.op   = ALU_ADD;
    dec.asel = ASEL_RS1;
    dec.rs1  = instr[19:15];
    dec.rs2  = instr[24:20];
    dec.rd   = instr[11:7];
    dec.f3   = f3;

    case (opc)
      OPC_OP: begin
        dec.wr  = 1'b1;
        dec.op  = op_of(f3, f7[5]);
        dec.bad = !((f7 == 7'h00) || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5)));
      end
      OPC_OPIMM: begin
        dec.wr       = 1'b1;
        dec.bsel_imm = 1'b1;
        dec.imm      = imm_i;
        dec.op       = op_of(f3, (f3 == 3'd5) && f7[5]);
        if (f3 == 3'd1)      dec.bad = (f7 != 7'h00);
        else if (f3 == 3'd5) dec.bad = !(f7 == 7'h00 || f7 == 7'h20);
      end
      OPC_LUI: begin
        dec.wr = 1'b1; dec.bsel_imm = 1'b1; dec.imm = imm_u; dec.asel = ASEL_ZERO;
      end
      OPC_AUIPC: begin
        dec.wr = 1'b1; dec.bsel_imm = 1'b1; dec.imm = imm_u; dec.asel = ASEL_PC;
      end
      OPC_JAL: begin
        dec.wr = 1'b1; dec.is_jal = 1'b1; dec.imm = imm_j;
      end
      OPC_JALR: begin
        dec.wr = 1'b1; dec.is_jalr = 1'b1; dec.bsel_imm = 1'b1; dec.imm = imm_i;
        dec.bad = (f3 != 3'd0);
      end
      OPC_BRANCH: begin
        dec.is_br = 1'b1; dec.imm = imm_b;
        dec.bad   = (f3 == 3'd2) || (f3 == 3'd3);
      end
      OPC_LOAD: begin
        dec.is_ld = 1'b1; dec.wr = 1'b1; dec.bsel_imm = 1'b1; dec.imm = imm_i;
        dec.bad   = (f3 != 3'b010);
      end
      OPC_STORE: begin
        dec.is_st = 1'b1; dec.bsel_imm = 1'b1; dec.imm = imm_s;
        dec.bad   = (f3 != 3'b010);
      end
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvc_alu.sv
module rvc_alu import rvc_pkg::*; (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      cmp_f3,
  input  logic [XLEN-1:0] ca,
  input  logic [XLEN-1:0] cb,
  output logic [XLEN-1:0] y,
  output logic            take
);
  logic [4:0] sh;
  logic       base;

  always_comb begin
    sh = b[4:0];
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << sh;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> sh;
      ALU_SRA:  y = $unsigned($signed(a) >>> sh);
      ALU_OR:   y = a | b;
      default:  y = a & b;
    endcase
  end

  always_comb begin
    case (cmp_f3[2:1])
      2'b00:   base = (ca == cb);
      2'b10:   base = $signed(ca) < $signed(cb);
      2'b11:   base = ca < cb;
      default: base = 1'b0;
    endcase
    take = base ^ cmp_f3[0];
  end
endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile import rvc_pkg::*; #(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  output logic [XLEN-1:0] rd1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       q <= '0;
        else if (we && wa == AW'(g))      q <= wd;
      end
      assign regs[g] = q;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/rv32_harvard_core.sv
module rv32_harvard_core import rvc_pkg::*; #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          NREG     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] ibus_haddr,
  output logic [1:0]  ibus_htrans,
  input  logic        ibus_hready,
  input  logic [31:0] ibus_hrdata,
  output logic [31:0] dbus_haddr,
  output logic [1:0]  dbus_htrans,
  output logic        dbus_hwrite,
  output logic [31:0] dbus_hwdata,
  input  logic        dbus_hready,
  input  logic [31:0] dbus_hrdata,
  output logic        halted
);
  localparam int AW = $clog2(NREG);

  state_e          state_q;
  logic [XLEN-1:0] pc_q, addr_q, wdata_q;
  logic [4:0]      rd_q;
  logic            st_q;

  dec_t            dec;
  logic [XLEN-1:0] rs1v, rs2v, opa, opb, alu_y;
  logic [XLEN-1:0] link, br_tgt, tgt, next_pc;
  logic            take, redirect, is_mem, fault, fire, mem_done;
  logic            rf_we;
  logic [4:0]      rf_wa;
  logic [XLEN-1:0] rf_wd;

  rvc_decode u_dec (.instr(ibus_hrdata), .dec(dec));

  rvc_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .wa(rf_wa[AW-1:0]), .wd(rf_wd),
    .ra1(dec.rs1[AW-1:0]), .rd1(rs1v),
    .ra2(dec.rs2[AW-1:0]), .rd2(rs2v)
  );

  always_comb begin
    case (dec.asel)
      ASEL_PC:   opa = pc_q;
      ASEL_ZERO: opa = '0;
      default:   opa = rs1v;
    endcase
    opb = dec.bsel_imm ? dec.imm : rs2v;
  end

  rvc_alu u_alu (
    .op(dec.op), .a(opa), .b(opb),
    .cmp_f3(dec.f3), .ca(rs1v), .cb(rs2v),
    .y(alu_y), .take(take)
  );

  always_comb begin
    link     = pc_q + 32'd4;
    br_tgt   = pc_q + dec.imm;
    redirect = dec.is_jal | dec.is_jalr | (dec.is_br & take);
    tgt      = dec.is_jalr ? {alu_y[XLEN-1:1], 1'b0} : br_tgt;
    next_pc  = redirect ? tgt : link;
    is_mem   = dec.is_ld | dec.is_st;
    fault    = dec.bad | (is_mem & (|alu_y[1:0])) | (redirect & (|tgt[1:0]));
    fire     = (state_q == ST_FDATA) && ibus_hready;
    mem_done = (state_q == ST_DDATA) && dbus_hready;

    if (state_q == ST_DDATA) begin
      rf_we = mem_done && !st_q && (rd_q != 5'd0);
      rf_wa = rd_q;
      rf_wd = dbus_hrdata;
    end else begin
      rf_we = fire && !fault && !is_mem && dec.wr && (dec.rd != 5'd0);
      rf_wa = dec.rd;
      rf_wd = (dec.is_jal | dec.is_jalr) ? link : alu_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      pc_q    <= RESET_PC;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      st_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_BOOT:  state_q <= ST_FADDR;
        ST_FADDR: if (ibus_hready) state_q <= ST_FDATA;
        ST_FDATA: if (fire) begin
          if (fault) begin
            state_q <= ST_HALT;
          end else if (is_mem) begin
            addr_q  <= alu_y;
            wdata_q <= rs2v;
            rd_q    <= dec.rd;
            st_q    <= dec.is_st;
            state_q <= ST_DADDR;
          end else begin
            pc_q    <= next_pc;
            state_q <= ST_FADDR;
          end
        end
        ST_DADDR: if (dbus_hready) state_q <= ST_DDATA;
        ST_DDATA: if (mem_done) begin
          pc_q    <= link;
          state_q <= ST_FADDR;
        end
        default:  state_q <= ST_HALT;
      endcase
    end
  end

  assign ibus_htrans = (state_q == ST_FADDR) ? HT_NONSEQ : HT_IDLE;
  assign ibus_haddr  = pc_q;
  assign dbus_htrans = (state_q == ST_DADDR) ? HT_NONSEQ : HT_IDLE;
  assign dbus_haddr  = addr_q;
  assign dbus_hwrite = st_q;
  assign dbus_hwdata = wdata_q;
  assign halted      = (state_q == ST_HALT);

  assert_fetch_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_htrans == HT_NONSEQ) |-> (ibus_haddr[1:0] == 2'b00));

  assert_data_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_htrans == HT_NONSEQ) |-> (dbus_haddr[1:0] == 2'b00));

  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((ibus_htrans != HT_IDLE) && (dbus_htrans != HT_IDLE)));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (ibus_htrans == HT_IDLE && dbus_htrans == HT_IDLE));

  assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_htrans == HT_NONSEQ && !ibus_hready) |=>
      (ibus_htrans == HT_NONSEQ && $stable(ibus_haddr)));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_htrans == HT_NONSEQ && !dbus_hready) |=>
      (dbus_htrans == HT_NONSEQ && $stable(dbus_haddr) && $stable(dbus_hwrite)));

  assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DDATA && !dbus_hready) |=> $stable(dbus_hwdata));
endmodule

// File: tb/sim_rv32_harvard_core.sv
`timescale 1ns/1ps
module sim_rv32_harvard_core;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] ibus_haddr, ibus_hrdata, dbus_haddr, dbus_hwdata, dbus_hrdata;
  logic [1:0]  ibus_htrans, dbus_htrans;
  logic        ibus_hready, dbus_hready, dbus_hwrite, halted;

  rv32_harvard_core u0 (
    .clk(clk), .rst_n(rst_n),
    .ibus_haddr(ibus_haddr), .ibus_htrans(ibus_htrans), .ibus_hready(ibus_hready),
    .ibus_hrdata(ibus_hrdata),
    .dbus_haddr(dbus_haddr), .dbus_htrans(dbus_htrans), .dbus_hwrite(dbus_hwrite),
    .dbus_hwdata(dbus_hwdata), .dbus_hready(dbus_hready), .dbus_hrdata(dbus_hrdata),
    .halted(halted)
  );

  logic [31:0] imem [0:2047];
  logic [31:0] dmem [0:511];
  logic [31:0] expv [0:511];
  string       tagv [0:511];
  int          nslot, ip, total, bad, cyc;
  logic        wait_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        i_ph = 1'b0, d_ph = 1'b0, d_pw = 1'b0;
  logic [31:0] i_pa = '0, d_pa = '0;
  logic [31:0] end_pc;
  logic        seen_end, have_prev;
  int          prev_cyc, dcount, quiet_fetch;
  logic [31:0] prev_addr;

  assign ibus_hready = !wait_mode | lfsr[0] | lfsr[3];
  assign dbus_hready = !wait_mode | lfsr[5] | lfsr[9];
  assign ibus_hrdata = imem[i_pa[12:2]];
  assign dbus_hrdata = dmem[d_pa[10:2]];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural zero-wait (or LFSR-stalled) memories
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ibus_hready) begin
      i_ph <= (ibus_htrans == 2'b10);
      i_pa <= ibus_haddr;
    end
    if (dbus_hready) begin
      if (d_ph && d_pw) dmem[d_pa[10:2]] <= dbus_hwdata;
      d_ph <= (dbus_htrans == 2'b10);
      d_pa <= dbus_haddr;
      d_pw <= dbus_hwrite;
    end
  end

  // port monitor: fetch spacing (R8), end detection, transfer counts
  always @(negedge clk) begin
    if (!rst_n) begin
      have_prev = 1'b0; seen_end = 1'b0; dcount = 0; quiet_fetch = 0;
    end else begin
      if (dbus_htrans == 2'b10 && dbus_hready) dcount++;
      if (ibus_htrans == 2'b10 && ibus_hready) begin
        if (halted) quiet_fetch++;
        if (have_prev && !wait_mode) begin
          logic [6:0] po;
          po = imem[prev_addr[12:2]][6:0];
          check("R8 fetch spacing", cyc - prev_cyc,
                (po == 7'h03 || po == 7'h23) ? 32'd4 : 32'd2);
        end
        have_prev = 1'b1; prev_cyc = cyc; prev_addr = ibus_haddr;
        if (ibus_haddr == end_pc) seen_end = 1'b1;
      end
    end
  end

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
    input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] rs1,
    input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] rs2,
    input logic [4:0] rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] rs2,
    input logic [4:0] rs1, input logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'h63};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] im, input logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'h6f};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[ip] = w; ip++;
  endtask
  task automatic li(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) >> 12;
    emit({hi[19:0], rd, 7'h37});
    emit(enc_i(v[11:0], rd, 3'd0, rd, 7'h13));
  endtask
  task automatic store_slot(input logic [4:0] rs, input string tag, input logic [31:0] v);
    logic [11:0] off;
    off = 12'(nslot * 4);
    expv[nslot] = v; tagv[nslot] = tag;
    emit(enc_s(off, rs, 5'd0));
    nslot++;
  endtask
  task automatic clear_all();
    for (int i = 0; i < 2048; i++) imem[i] = 32'h0;
    for (int i = 0; i < 512; i++) dmem[i] = 32'hDEADBEEF;
    ip = 0; nslot = 0;
  endtask
  task automatic finish_prog();
    end_pc = 32'(ip * 4);
    emit(enc_j(21'd0, 5'd0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 htrans idle right after reset", {30'd0, ibus_htrans}, 32'd0);
    @(negedge clk);
    check("R1 first fetch type", {30'd0, ibus_htrans}, 32'd2);
    check("R1 first fetch addr", ibus_haddr, 32'h0);
    check("R1 data idle", {30'd0, dbus_htrans}, 32'd0);
    check("R1 not halted", {31'd0, halted}, 32'd0);
  endtask

  task automatic run_prog(input int limit);
    int n;
    do_reset();
    n = 0;
    while (!seen_end && !halted && n < limit) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic verify();
    for (int s = 0; s < nslot; s++)
      check(wait_mode ? {"R9 stalled ", tagv[s]} : tagv[s], dmem[s], expv[s]);
  endtask

  function automatic logic [31:0] ref_r(input int k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a << b[4:0];
      3: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4: return (a < b) ? 32'd1 : 32'd0;
      5: return a ^ b;
      6: return a >> b[4:0];
      7: return $unsigned($signed(a) >>> b[4:0]);
      8: return a | b;
      default: return a & b;
    endcase
  endfunction
  function automatic logic [2:0] f3_r(input int k);
    case (k)
      0, 1: return 3'd0;  2: return 3'd1;  3: return 3'd2;  4: return 3'd3;
      5: return 3'd4;     6, 7: return 3'd5; 8: return 3'd6; default: return 3'd7;
    endcase
  endfunction
  function automatic logic ref_br(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    case (f3)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  logic [31:0] vals [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5679};
  logic [2:0]  brf  [6] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
  logic [11:0] imms [6] = '{12'h000, 12'h001, 12'hFFF, 12'h7FF, 12'h800, 12'h007};

  task automatic build_rr();
    clear_all();
    for (int x = 0; x < 5; x++) begin
      for (int y = 0; y < 5; y++) begin
        li(5'd1, vals[x]); li(5'd2, vals[y]);
        for (int k = 0; k < 10; k++) begin
          emit(enc_r((k == 1 || k == 7) ? 7'h20 : 7'h00, 5'd2, 5'd1, f3_r(k), 5'd3));
          store_slot(5'd3, "R2 reg-reg op", ref_r(k, vals[x], vals[y]));
        end
        for (int j = 0; j < 6; j++) begin
          emit(enc_i(12'd1, 5'd0, 3'd0, 5'd3, 7'h13));
          emit(enc_b(13'd8, 5'd2, 5'd1, brf[j]));
          emit(enc_i(12'd2, 5'd0, 3'd0, 5'd3, 7'h13));
          store_slot(5'd3, "R4 branch", ref_br(brf[j], vals[x], vals[y]) ? 32'd1 : 32'd2);
        end
      end
    end
    finish_prog();
  endtask

  task automatic build_ri();
    logic [2:0]  f3s [9] = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd6, 3'd7, 3'd1, 3'd5, 3'd5};
    clear_all();
    for (int x = 0; x < 5; x++) begin
      li(5'd1, vals[x]);
      for (int m = 0; m < 6; m++) begin
        for (int k = 0; k < 9; k++) begin
          logic [11:0] im;
          logic [31:0] se, r;
          im = imms[m];
          if (k >= 6) im = {(k == 8) ? 7'h20 : 7'h00, imms[m][4:0]};
          se = {{20{im[11]}}, im};
          case (k)
            0: r = vals[x] + se;
            1: r = ($signed(vals[x]) < $signed(se)) ? 32'd1 : 32'd0;
            2: r = (vals[x] < se) ? 32'd1 : 32'd0;
            3: r = vals[x] ^ se;
            4: r = vals[x] | se;
            5: r = vals[x] & se;
            6: r = vals[x] << im[4:0];
            7: r = vals[x] >> im[4:0];
            default: r = $unsigned($signed(vals[x]) >>> im[4:0]);
          endcase
          emit(enc_i(im, 5'd1, f3s[k], 5'd3, 7'h13));
          store_slot(5'd3, "R3 reg-imm op", r);
        end
      end
    end
    finish_prog();
  endtask

  task automatic build_misc();
    logic [31:0] p, a;
    clear_all();
    emit({20'hABCDE, 5'd5, 7'h37});
    store_slot(5'd5, "R5 lui", 32'hABCDE000);
    p = 32'(ip * 4);
    emit({20'h00001, 5'd6, 7'h17});
    store_slot(5'd6, "R5 auipc", p + 32'h1000);
    p = 32'(ip * 4);
    emit(enc_j(21'd8, 5'd7));
    emit(enc_i(12'd99, 5'd0, 3'd0, 5'd5, 7'h13));
    store_slot(5'd7, "R5 jal link", p + 32'd4);
    a = 32'(ip * 4);
    emit(enc_i(12'(a + 32'd12), 5'd0, 3'd0, 5'd10, 7'h13));
    emit(enc_i(12'd1, 5'd10, 3'd0, 5'd8, 7'h67));
    emit(enc_i(12'd99, 5'd0, 3'd0, 5'd5, 7'h13));
    store_slot(5'd8, "R5 jalr link", a + 32'd8);
    store_slot(5'd5, "R5 jumps skip", 32'hABCDE000);
    emit(enc_i(12'd5, 5'd0, 3'd0, 5'd0, 7'h13));
    store_slot(5'd0, "R7 x0 after addi", 32'd0);
    emit(enc_r(7'h00, 5'd5, 5'd5, 3'd0, 5'd0));
    emit(enc_r(7'h00, 5'd0, 5'd0, 3'd0, 5'd16));
    store_slot(5'd16, "R7 x0 reads zero", 32'd0);
    emit(enc_i(12'd0, 5'd0, 3'b010, 5'd9, 7'h03));
    store_slot(5'd9, "R6 lw", 32'hABCDE000);
    emit(enc_i(12'd40, 5'd0, 3'd0, 5'd12, 7'h13));
    emit(enc_i(12'hFDC, 5'd12, 3'b010, 5'd13, 7'h03));
    store_slot(5'd13, "R6 lw negative offset", expv[1]);
    emit(enc_i(12'd3, 5'd0, 3'd0, 5'd14, 7'h13));
    emit(enc_i(12'd0, 5'd0, 3'd0, 5'd15, 7'h13));
    emit(enc_i(12'd5, 5'd15, 3'd0, 5'd15, 7'h13));
    emit(enc_i(12'hFFF, 5'd14, 3'd0, 5'd14, 7'h13));
    emit(enc_b(13'h1FF8, 5'd0, 5'd14, 3'd1));
    store_slot(5'd15, "R4 backward loop", 32'd15);
    finish_prog();
  endtask

  initial begin
    #(8 * 190000);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] badw [10];
    string       badt [10];
    total = 0; bad = 0; cyc = 0; end_pc = 32'hFFFF_FFF0;

    for (int w = 0; w < 2; w++) begin
      wait_mode = (w == 1);
      build_rr();   run_prog(40000); verify();
      build_ri();   run_prog(20000); verify();
      build_misc(); run_prog(2000);  verify();
    end
    wait_mode = 1'b0;

    badw[0] = 32'h0000_0000;                          badt[0] = "R10 zero word";
    badw[1] = enc_i(12'd0, 5'd0, 3'd0, 5'd2, 7'h03);  badt[1] = "R10 byte load";
    badw[2] = 32'h0000_0073;                          badt[2] = "R10 ecall";
    badw[3] = 32'h0000_000F;                          badt[3] = "R10 fence";
    badw[4] = enc_r(7'h20, 5'd2, 5'd1, 3'd1, 5'd3);   badt[4] = "R10 bad funct7 reg";
    badw[5] = enc_i(12'h021, 5'd1, 3'd1, 5'd3, 7'h13); badt[5] = "R10 bad funct7 imm";
    badw[6] = enc_i(12'd2, 5'd0, 3'b010, 5'd3, 7'h03); badt[6] = "R11 misaligned lw";
    badw[7] = enc_s(12'd1, 5'd1, 5'd0);               badt[7] = "R11 misaligned sw";
    badw[8] = enc_i(12'd6, 5'd0, 3'd0, 5'd5, 7'h67);  badt[8] = "R11 misaligned jalr";
    badw[9] = enc_b(13'd6, 5'd0, 5'd0, 3'd0);         badt[9] = "R11 misaligned branch";

    for (int c = 0; c < 10; c++) begin
      clear_all();
      emit(enc_i(12'd7, 5'd0, 3'd0, 5'd1, 7'h13));
      emit(enc_s(12'd0, 5'd1, 5'd0));
      emit(badw[c]);
      emit(enc_s(12'd4, 5'd1, 5'd0));
      finish_prog();
      run_prog(200);
      check({badt[c], " halted"}, {31'd0, halted}, 32'd1);
      repeat (16) @(negedge clk);
      check({badt[c], " halt sticky"}, {31'd0, halted}, 32'd1);
      check({badt[c], " no fetch after halt"}, 32'(quiet_fetch), 32'd0);
      check({badt[c], " one data transfer"}, 32'(dcount), 32'd1);
      check({badt[c], " earlier store kept"}, dmem[0], 32'd7);
      check({badt[c], " later store absent"}, dmem[1], 32'hDEADBEEF);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule